// File: doc/BRIEF.md
# Free-Running Time Base with Threshold Interrupt

This block keeps a wide time-base count that advances by one on each cycle where its tick input is high. The count never stops and cannot be loaded. It has one compare slot. Software programs a 64-bit threshold into that slot and sets an arm bit. When the count is equal to or greater than the threshold, a sticky flag sets and the interrupt line goes high. Software drops the interrupt by clearing the arm bit, which also clears the flag.

Access is through a simple 32-bit register port. A write takes effect on the clock edge where it is presented. A read returns its data one cycle later. The count is wider than one bus word. Reading its low word therefore captures the upper count bits in a holding register, and a later read of the high word returns that captured value. Two reads give a coherent value with no retry loop.

Top module: `syscnt_timer`

## Requirements
- R1: The counter is CNT_W (default 56) bits wide. It increments by exactly one on every clock edge where `tick_i` is high and holds its value otherwise.
- R2: Register offsets: control at 0x00 (arm bit at bit 0, read/write; flag at bit 2, read-only), count low at 0x08, count high at 0x0C, threshold low at 0x10, threshold high at 0x14. `rd_data_o` presents the addressed value on the cycle after `rd_en_i`. Any other offset reads as zero.
- R3: While armed, the flag sets on the clock edge after the count, zero-extended to 64 bits, is greater than or equal to the threshold. Equality fires. A threshold that is already passed fires one cycle after arming.
- R4: Writing the control register with bit 0 at 0 disarms the block, clears the flag and drops `irq_o` at that same edge. This is the only way to clear the flag.
- R5: Once set, the flag stays set while armed, even if the threshold is rewritten to a later time.
- R6: A read of count low stores count bits CNT_W-1:32. A read of count high returns the stored bits, zero-extended to 32 bits, whatever the live count is at that moment.
- R7: `irq_o` is high exactly when the flag and the arm bit are both set, and it changes at the same edge as they do.
- R8: Writes to the count low and count high registers are ignored. Bit 2 of a control write is ignored.
- R9: A synchronous active-high reset loads the counter with CNT_RST_VAL (default 0). It clears the threshold, the arm bit, the flag, the stored high count, `rd_data_o` and `irq_o`.
- R10: All 64 threshold bits take part in the comparison. A threshold with any bit above CNT_W-1 set is never reached.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count advance strobe, one increment per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Level interrupt: flag gated by the arm bit |

## Verification
The bench builds the block with the default 56-bit counter and a reset count of 0xFFFF_FFF0. The low word therefore wraps after sixteen ticks. This puts a low-word rollover between the low and high reads within a few dozen cycles, so the bench can confirm that the stored high word, and not the live one, is returned. The default width also lets the bench place a threshold bit above the counter's top bit and confirm that such a threshold never fires.

// File: rtl/syscnt_pkg.sv
package syscnt_pkg;

  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h08;
  localparam logic [7:0] OFS_CNT_HI = 8'h0C;
  localparam logic [7:0] OFS_CMP_LO = 8'h10;
  localparam logic [7:0] OFS_CMP_HI = 8'h14;

  localparam int unsigned BIT_ARM  = 0;
  localparam int unsigned BIT_FLAG = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP
  } sel_e;

  function automatic sel_e decode_sel(input logic [7:0] a);
    sel_e s;
    case (a)
      OFS_CTRL:               s = SEL_CTRL;
      OFS_CNT_LO:             s = SEL_CNT_LO;
      OFS_CNT_HI:             s = SEL_CNT_HI;
      OFS_CMP_LO, OFS_CMP_HI: s = SEL_CMP;
      default:                s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/syscnt_counter.sv
module syscnt_counter #(
  parameter int unsigned CNT_W       = 56,
  parameter logic [63:0] CNT_RST_VAL = 64'd0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] RST_CNT = CNT_RST_VAL[CNT_W-1:0];

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_CNT;
    end else if (tick_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/syscnt_regs.sv
module syscnt_regs
  import syscnt_pkg::*;
#(
  parameter int unsigned CNT_W  = 56,
  parameter int unsigned CMP_W  = 64,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              flag_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [CMP_W-1:0]  cmp_o,
  output logic              arm_q_o,
  output logic              arm_nxt_o,
  output logic              ack_o
);

  localparam int unsigned HI_W      = CNT_W - BUS_W;
  localparam int unsigned CMP_WORDS = CMP_W / BUS_W;

  logic [7:0]       addr8;
  sel_e             sel;
  logic             arm_q;
  logic             arm_nxt;
  logic             ctrl_wr;
  logic [HI_W-1:0]  hi_hold_q;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] cmp_w [CMP_WORDS];

  assign addr8   = 8'(addr_i);
  assign sel     = decode_sel(addr8);
  assign ctrl_wr = wr_en_i && (sel == SEL_CTRL);

  // Arm bit: next value is visible to the compare stage for aligned irq
  always_comb begin
    arm_nxt = arm_q;
    if (ctrl_wr) begin
      arm_nxt = wdata_i[BIT_ARM];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q <= 1'b0;
    end else begin
      arm_q <= arm_nxt;
    end
  end

  assign ack_o     = ctrl_wr && !wdata_i[BIT_ARM];
  assign arm_q_o   = arm_q;
  assign arm_nxt_o = arm_nxt;

  // Threshold words, one register per bus word
  for (genvar w = 0; w < CMP_WORDS; w++) begin : g_cmp
    localparam logic [7:0] WORD_OFS = 8'(OFS_CMP_LO + 8'(4 * w));
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_w[w] <= '0;
      end else if (wr_en_i && (addr8 == WORD_OFS)) begin
        cmp_w[w] <= wdata_i;
      end
    end
    assign cmp_o[w*BUS_W +: BUS_W] = cmp_w[w];
  end

  // Upper count bits captured on a low-word read
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_hold_q <= '0;
    end else if (rd_en_i && (sel == SEL_CNT_LO)) begin
      hi_hold_q <= cnt_i[CNT_W-1:BUS_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_CTRL: begin
        rd_mux[BIT_ARM]  = arm_q;
        rd_mux[BIT_FLAG] = flag_i;
      end
      SEL_CNT_LO: rd_mux = cnt_i[BUS_W-1:0];
      SEL_CNT_HI: rd_mux = BUS_W'(hi_hold_q);
      SEL_CMP: begin
        for (int w = 0; w < CMP_WORDS; w++) begin
          if (addr8 == 8'(OFS_CMP_LO + 8'(4 * w))) begin
            rd_mux = cmp_w[w];
          end
        end
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      rd_data_o <= rd_mux;
    end
  end

endmodule

// File: rtl/syscnt_compare.sv
module syscnt_compare #(
  parameter int unsigned CNT_W = 56,
  parameter int unsigned CMP_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             arm_q_i,
  input  logic             arm_nxt_i,
  input  logic             ack_i,
  output logic             flag_o,
  output logic             irq_o
);

  logic hit;
  logic flag_q;
  logic flag_nxt;
  logic irq_q;

  assign hit = (CMP_W'(cnt_i) >= cmp_i);

  // Clear wins over set; flag is sticky otherwise
  always_comb begin
    if (ack_i) begin
      flag_nxt = 1'b0;
    end else if (flag_q) begin
      flag_nxt = 1'b1;
    end else begin
      flag_nxt = arm_q_i && hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && arm_nxt_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/syscnt_timer.sv
module syscnt_timer
  import syscnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 56,
  parameter int unsigned CMP_W       = 64,
  parameter int unsigned ADDR_W      = 5,
  parameter logic [63:0] CNT_RST_VAL = 64'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] cmp_q;
  logic             arm_q;
  logic             arm_nxt;
  logic             ack;
  logic             flag_q;

  syscnt_counter #(
    .CNT_W      (CNT_W),
    .CNT_RST_VAL(CNT_RST_VAL)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick_i(tick_i),
    .cnt_o (cnt_q)
  );

  syscnt_regs #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt_q),
    .flag_i   (flag_q),
    .rd_data_o(rd_data_o),
    .cmp_o    (cmp_q),
    .arm_q_o  (arm_q),
    .arm_nxt_o(arm_nxt),
    .ack_o    (ack)
  );

  syscnt_compare #(
    .CNT_W(CNT_W),
    .CMP_W(CMP_W)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .cnt_i    (cnt_q),
    .cmp_i    (cmp_q),
    .arm_q_i  (arm_q),
    .arm_nxt_i(arm_nxt),
    .ack_i    (ack),
    .flag_o   (flag_q),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/syscnt_checker.sv
module syscnt_checker #(
  parameter int unsigned CNT_W = 56,
  parameter int unsigned CMP_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_i,
  input logic             ack,
  input logic             arm_q,
  input logic             flag_q,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CMP_W-1:0] cmp_q
);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q)); // R1

  AST_GE_SETS: assert property (@(posedge clk) disable iff (rst)
    (arm_q && (CMP_W'(cnt_q) >= cmp_q) && !ack) |=> flag_q); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack |=> (!flag_q && !irq_o)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack) |=> flag_q); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o == (flag_q && arm_q)); // R7

  AST_FLAG_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    !arm_q |-> !flag_q); // R4

endmodule

bind syscnt_timer syscnt_checker #(
  .CNT_W(CNT_W),
  .CMP_W(CMP_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .tick_i(tick_i),
  .ack   (ack),
  .arm_q (arm_q),
  .flag_q(flag_q),
  .irq_o (irq_o),
  .cnt_q (cnt_q),
  .cmp_q (cmp_q)
);

// File: tb/tb_syscnt_timer.sv
`timescale 1ns/1ps
module tb_syscnt_timer;

  localparam logic [63:0] RST_CNT = 64'h0000_0000_FFFF_FFF0;

  localparam logic [2:0] OP_WR  = 3'd0;
  localparam logic [2:0] OP_RD  = 3'd1;
  localparam logic [2:0] OP_TK  = 3'd2;
  localparam logic [2:0] OP_ID  = 3'd3;
  localparam logic [2:0] OP_IRQ = 3'd4;

  localparam int NVEC = 62;
  // {op, requirement, address, data/expected/count}
  localparam logic [43:0] VEC [NVEC] = '{
    {OP_RD,  4'd9,  5'h00, 32'h0},          // R9 control after reset
    {OP_RD,  4'd9,  5'h08, 32'hFFFF_FFF0},  // R9 count reset value
    {OP_RD,  4'd6,  5'h0C, 32'h0},          // R6
    {OP_RD,  4'd9,  5'h10, 32'h0},          // R9
    {OP_IRQ, 4'd9,  5'h00, 32'h0},          // R9
    {OP_WR,  4'd0,  5'h14, 32'h0},
    {OP_WR,  4'd0,  5'h10, 32'hFFFF_FFF2},
    {OP_WR,  4'd0,  5'h00, 32'h1},
    {OP_ID,  4'd0,  5'h00, 32'd2},
    {OP_IRQ, 4'd3,  5'h00, 32'h0},          // R3 below threshold
    {OP_TK,  4'd0,  5'h00, 32'd1},
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd3,  5'h00, 32'h0},          // R3 one below
    {OP_TK,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd3,  5'h00, 32'h0},          // R3 one-cycle latency
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd3,  5'h00, 32'h1},          // R3 equality fires
    {OP_RD,  4'd2,  5'h00, 32'h5},          // R2 arm and flag bits
    {OP_WR,  4'd0,  5'h14, 32'h10},
    {OP_ID,  4'd0,  5'h00, 32'd2},
    {OP_IRQ, 4'd5,  5'h00, 32'h1},          // R5 sticky
    {OP_WR,  4'd0,  5'h00, 32'h0},
    {OP_IRQ, 4'd4,  5'h00, 32'h0},          // R4 ack
    {OP_RD,  4'd4,  5'h00, 32'h0},          // R4
    {OP_WR,  4'd0,  5'h00, 32'h1},
    {OP_ID,  4'd0,  5'h00, 32'd2},
    {OP_IRQ, 4'd3,  5'h00, 32'h0},          // R3 future threshold
    {OP_RD,  4'd2,  5'h00, 32'h1},          // R2
    {OP_WR,  4'd0,  5'h00, 32'h0},
    {OP_WR,  4'd0,  5'h14, 32'h0},
    {OP_WR,  4'd0,  5'h10, 32'h5},
    {OP_WR,  4'd0,  5'h00, 32'h1},
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd3,  5'h00, 32'h1},          // R3 past threshold
    {OP_WR,  4'd0,  5'h00, 32'h0},
    {OP_WR,  4'd0,  5'h08, 32'h0},          // R8
    {OP_WR,  4'd0,  5'h0C, 32'hFFFF_FFFF},  // R8
    {OP_WR,  4'd0,  5'h00, 32'h4},          // R8
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_RD,  4'd8,  5'h00, 32'h0},          // R8 flag not writable
    {OP_RD,  4'd8,  5'h08, 32'hFFFF_FFF2},  // R8 count untouched
    {OP_TK,  4'd0,  5'h00, 32'd20},
    {OP_RD,  4'd6,  5'h0C, 32'h0},          // R6 held across wrap
    {OP_RD,  4'd6,  5'h08, 32'h6},          // R6
    {OP_RD,  4'd6,  5'h0C, 32'h1},          // R6 new capture
    {OP_WR,  4'd0,  5'h14, 32'h1},
    {OP_WR,  4'd0,  5'h10, 32'h10},
    {OP_WR,  4'd0,  5'h00, 32'h1},
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd10, 5'h00, 32'h0},          // R10 high word compare
    {OP_TK,  4'd0,  5'h00, 32'd10},
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd10, 5'h00, 32'h1},          // R10
    {OP_WR,  4'd0,  5'h00, 32'h0},
    {OP_WR,  4'd0,  5'h14, 32'h0100_0000},
    {OP_WR,  4'd0,  5'h10, 32'h0},
    {OP_WR,  4'd0,  5'h00, 32'h1},
    {OP_TK,  4'd0,  5'h00, 32'd5},
    {OP_ID,  4'd0,  5'h00, 32'd1},
    {OP_IRQ, 4'd10, 5'h00, 32'h0},          // R10 unreachable
    {OP_RD,  4'd2,  5'h14, 32'h0100_0000},  // R2
    {OP_RD,  4'd2,  5'h04, 32'h0}           // R2 unmapped
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  syscnt_timer #(.CNT_RST_VAL(RST_CNT)) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    addr_i = a; rd_en_i = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9", 32'(irq_o), 32'h0);
    check("R9", rd_data_o, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  op;
      logic [3:0]  rq;
      logic [4:0]  ad;
      logic [31:0] dv;
      {op, rq, ad, dv} = VEC[i];
      case (op)
        OP_WR:  reg_wr(ad, dv);
        OP_RD:  begin reg_rd(ad, rd); check($sformatf("R%0d", rq), rd, dv); end
        OP_TK:  ticks(int'(dv));
        OP_ID:  idle(int'(dv));
        default: check($sformatf("R%0d", rq), 32'(irq_o), dv);
      endcase
    end

    // R1: count advances by one per tick cycle (now 0x1_0000_0015)
    ticks(3);
    reg_rd(5'h08, rd);
    check("R1", rd, 32'h0000_0018);
    reg_rd(5'h0C, rd);
    check("R1", rd, 32'h1);

    // R7: fire again, then R9: reset in mid-run
    reg_wr(5'h14, 32'h0);
    idle(1);
    check("R7", 32'(irq_o), 32'h1);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R9", 32'(irq_o), 32'h0);
    check("R9", rd_data_o, 32'h0);
    reg_rd(5'h00, rd);
    check("R9", rd, 32'h0);
    reg_rd(5'h14, rd);
    check("R9", rd, 32'h0);
    reg_rd(5'h08, rd);
    check("R9", rd, 32'hFFFF_FFF0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule